// File: doc/BRIEF.md
# GPIO Pin Interrupt Aggregator

This block watches a bank of general-purpose input pins, one already synchronised level per pin, and turns each into a latched interrupt pending bit. Each pin has two mode bits, a trigger-select bit and an invert bit. Together they choose rising-edge, falling-edge, level-low or level-high detection. Pending bits are kept in a packed status bitmap and masked by a packed enable bitmap. Both bitmaps are split into 32-bit words. The block drives one combined, registered interrupt request to a parent controller.

Software reaches both bitmaps through a simple single-cycle register port. A read returns the word selected by the address in the same cycle. Writing a status word clears every bit written as one and leaves bits written as zero alone. Writing an enable word replaces it. The mode bits and the pin levels come from the pad configuration logic, which sits outside this block.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: With trigger-select 0 and invert 0, a 0-to-1 change of a pin's level sets its status bit at the next clock edge. A level that stays high after the bit is cleared does not set it again.
- R2: With trigger-select 0 and invert 1, a 1-to-0 change of a pin's level sets its status bit at the next clock edge. A 0-to-1 change does not set it.
- R3: With trigger-select 1 and invert 0, the status bit is set on every clock edge while the pin is low. A clear written while the pin is still low has no lasting effect, and a clear written after the pin returns high sticks.
- R4: With trigger-select 1 and invert 1, the status bit is set on every clock edge while the pin is high, under the same clear rules as R3.
- R5: Status words sit at byte addresses 0x80, 0x84 and 0x88. Pin p appears at bit p mod 32 of word p/32. Writing a word clears the bits written as 1 and leaves the bits written as 0 unchanged. A status bit never rises without a detect event.
- R6: Enable words sit at 0x90, 0x94 and 0x98, use the same bit packing, and read back what was written. The enable bit for nonexistent pin 95 reads 0. Enable changes only on a write.
- R7: The request output is a register. It goes high one clock after some pin has both its status bit and its enable bit set. It goes low one clock after the last such pin is cleared or masked. A pending pin whose enable bit is 0 does not raise it.
- R8: When a detect event and a clearing write hit the same status bit on the same clock edge, the bit stays set. Other bits in the same write are still cleared.
- R9: Reset clears all status and enable bits and the request. The previous-level register follows the pins during reset, so a level already present when reset is released causes no edge event.
- R10: A write to any other address, including an unaligned one, changes neither bitmap. Reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | 95 | Synchronised level of each pin |
| trig_sel | input | 95 | Per-pin trigger select: 0 edge, 1 level |
| trig_inv | input | 95 | Per-pin invert: picks falling edge or high level |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from the address |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
A new detect event on a pin and a software clear of that same status bit can land on one clock edge. The bench provokes this by first setting the bit of a rising-edge pin and then letting the pin fall. It then drives the next rising edge in the same cycle as a write of ones to that status word. The write also carries a second, already pending bit that has no new event. The bench expects the colliding bit to read back as set and the other bit to read back as cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PINS  = 95;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'h90;

    // {trigger-select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    function automatic logic trig_hit(trig_mode_e mode, logic cur, logic prv);
        logic hit;
        unique case (mode)
            TRIG_RISE: hit = cur & ~prv;
            TRIG_FALL: hit = ~cur & prv;
            TRIG_LOW:  hit = ~cur;
            default:   hit = cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = gpio_irq_pkg::NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_sel,
    input  logic [NUM_PINS-1:0] trig_inv,
    output logic [NUM_PINS-1:0] det_evt
);

    logic [NUM_PINS-1:0] prev_q;

    // Tracks the pins during reset too, so no edge appears at release.
    always_ff @(posedge clk) begin
        prev_q <= pin_level;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign det_evt[i] = trig_hit(trig_mode_e'({trig_sel[i], trig_inv[i]}),
                                     pin_level[i], prev_q[i]);
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((det_evt & ~trig_sel & ~(pin_level ^ $past(pin_level))) == '0)); // R1
    AST_LEVEL_MATCHES: assert property (@(posedge clk) disable iff (rst)
        ((det_evt & trig_sel & (pin_level ^ trig_inv)) == '0)); // R3

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = gpio_irq_pkg::NUM_PINS,
    parameter int WORD_W   = gpio_irq_pkg::WORD_W,
    parameter int ADDR_W   = gpio_irq_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] STAT_BASE = gpio_irq_pkg::STAT_BASE,
    parameter logic [ADDR_W-1:0] EN_BASE   = gpio_irq_pkg::EN_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] det_evt,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] stat_q,
    output logic [NUM_PINS-1:0] en_q
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int BSEL_W    = $clog2(WORD_W / 8);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * (WORD_W / 8));

    logic [ADDR_W-1:0] s_off, e_off;
    logic              s_hit, e_hit;
    logic [WIDX_W-1:0] s_idx, e_idx;

    assign s_off = bus_addr - STAT_BASE;
    assign e_off = bus_addr - EN_BASE;
    assign s_hit = (bus_addr >= STAT_BASE) && (s_off < SPAN) && (s_off[BSEL_W-1:0] == '0);
    assign e_hit = (bus_addr >= EN_BASE) && (e_off < SPAN) && (e_off[BSEL_W-1:0] == '0);
    assign s_idx = s_off[BSEL_W +: WIDX_W];
    assign e_idx = e_off[BSEL_W +: WIDX_W];

    logic [NUM_PINS-1:0] clr_vec, en_d;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        localparam logic [WIDX_W-1:0] WSEL = WIDX_W'(p / WORD_W);
        assign clr_vec[p] = bus_wr && s_hit && (s_idx == WSEL) && bus_wdata[p % WORD_W];
        assign en_d[p]    = (bus_wr && e_hit && (e_idx == WSEL)) ? bus_wdata[p % WORD_W] : en_q[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            // Detect is ORed after the clear: a colliding event wins.
            stat_q <= (stat_q & ~clr_vec) | det_evt;
            en_q   <= en_d;
        end
    end

    logic [PAD_W-1:0]  stat_pad, en_pad;
    logic [WORD_W-1:0] stat_word [NUM_WORDS];
    logic [WORD_W-1:0] en_word   [NUM_WORDS];

    always_comb begin
        stat_pad = '0;
        en_pad   = '0;
        stat_pad[NUM_PINS-1:0] = stat_q;
        en_pad[NUM_PINS-1:0]   = en_q;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign stat_word[w] = stat_pad[w*WORD_W +: WORD_W];
        assign en_word[w]   = en_pad[w*WORD_W +: WORD_W];
    end

    always_comb begin
        if (s_hit)      bus_rdata = stat_word[s_idx];
        else if (e_hit) bus_rdata = en_word[e_idx];
        else            bus_rdata = '0;
    end

    AST_DETECT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(det_evt)) == $past(det_evt))); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr_vec & ~det_evt)) == '0)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(det_evt)) == '0)); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(en_q)); // R6

endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = gpio_irq_pkg::NUM_PINS,
    parameter int WORD_W   = gpio_irq_pkg::WORD_W,
    parameter int ADDR_W   = gpio_irq_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_sel,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] det_evt, stat_q, en_q;
    logic                pend_any;

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .trig_sel  (trig_sel),
        .trig_inv  (trig_inv),
        .det_evt   (det_evt)
    );

    gpio_irq_regs #(
        .NUM_PINS  (NUM_PINS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (ADDR_W'(STAT_BASE)),
        .EN_BASE   (ADDR_W'(EN_BASE))
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .det_evt   (det_evt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_q    (stat_q),
        .en_q      (en_q)
    );

    assign pend_any = |(stat_q & en_q);

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= pend_any;
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        pend_any |=> irq_out); // R7
    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        !pend_any |=> !irq_out); // R7

endmodule

// File: tb/tb_gpio_irq_aggregator.sv
`timescale 1ns/1ps
module tb_gpio_irq_aggregator;
    import gpio_irq_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_PINS-1:0] pin_level = '0;
    logic [NUM_PINS-1:0] trig_sel  = '0;
    logic [NUM_PINS-1:0] trig_inv  = '0;
    logic                bus_wr    = 1'b0;
    logic [7:0]          bus_addr  = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    gpio_irq_aggregator dut (
        .clk(clk), .rst(rst), .pin_level(pin_level), .trig_sel(trig_sel),
        .trig_inv(trig_inv), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] stat_addr(int p);
        return 8'(8'h80 + 4 * (p / 32));
    endfunction

    function automatic logic [31:0] pin_bit(int p);
        return 32'h1 << (p % 32);
    endfunction

    task automatic clear_all();
        bus_write(8'h80, '1); bus_write(8'h84, '1); bus_write(8'h88, '1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pin_level[3] = 1'b1;
        step(4);
        rst = 1'b0;
        step(2);
        for (int w = 0; w < 3; w++) begin
            bus_read(8'(8'h80 + 4*w), d); check("R9 status zero after reset", d, 0);
            bus_read(8'(8'h90 + 4*w), d); check("R9 enable zero after reset", d, 0);
        end
        check("R9 irq low after reset", 32'(irq_out), 0);
    endtask

    task automatic t_rising();
        logic [31:0] d;
        pin_level[40] = 1'b1;
        step(1);
        bus_read(stat_addr(40), d); check("R1 rising sets bit", d, pin_bit(40));
        bus_write(stat_addr(40), pin_bit(40));
        step(2);
        bus_read(stat_addr(40), d); check("R1 held high no retrigger", d, 0);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        trig_inv[70] = 1'b1; pin_level[70] = 1'b1;
        step(2);
        bus_read(stat_addr(70), d); check("R2 rise ignored in falling mode", d, 0);
        pin_level[70] = 1'b0;
        step(1);
        bus_read(stat_addr(70), d); check("R2 falling sets bit", d, pin_bit(70));
        bus_write(stat_addr(70), pin_bit(70));
        trig_inv[70] = 1'b0;
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        trig_sel[94] = 1'b1; pin_level[94] = 1'b1;
        step(2);
        bus_read(stat_addr(94), d); check("R3 high level inactive", d, 0);
        pin_level[94] = 1'b0;
        step(1);
        bus_read(stat_addr(94), d); check("R3 low level sets bit", d, pin_bit(94));
        bus_write(stat_addr(94), pin_bit(94));
        bus_read(stat_addr(94), d); check("R3 clear while low does not stick", d, pin_bit(94));
        pin_level[94] = 1'b1;
        step(1);
        bus_write(stat_addr(94), pin_bit(94));
        step(1);
        bus_read(stat_addr(94), d); check("R3 clear after level gone sticks", d, 0);
        trig_sel[94] = 1'b0;
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        trig_sel[0] = 1'b1; trig_inv[0] = 1'b1;
        step(2);
        bus_read(8'h80, d); check("R4 low level inactive", d, 0);
        pin_level[0] = 1'b1;
        step(1);
        bus_read(8'h80, d); check("R4 high level sets bit", d, 32'h1);
        bus_write(8'h80, 32'h1);
        bus_read(8'h80, d); check("R4 clear while high does not stick", d, 32'h1);
        pin_level[0] = 1'b0;
        step(1);
        bus_write(8'h80, 32'h1);
        bus_read(8'h80, d); check("R4 clear after level gone sticks", d, 0);
        trig_sel[0] = 1'b0; trig_inv[0] = 1'b0;
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pin_level[1] = 1'b1; pin_level[2] = 1'b1;
        step(1);
        bus_read(8'h80, d); check("R5 two pins pending", d, 32'h6);
        bus_write(8'h80, 32'h0);
        bus_read(8'h80, d); check("R5 zero write leaves bits", d, 32'h6);
        bus_write(8'h80, 32'h2);
        bus_read(8'h80, d); check("R5 one clears only its bit", d, 32'h4);
        bus_write(8'h80, '1);
        bus_read(8'h80, d); check("R5 all ones clears word", d, 0);
    endtask

    task automatic t_enable_irq();
        logic [31:0] d;
        clear_all();
        bus_write(8'h94, '1);
        bus_read(8'h94, d); check("R6 enable readback", d, 32'hFFFF_FFFF);
        bus_write(8'h98, '1);
        bus_read(8'h98, d); check("R6 top enable word pin 95 absent", d, 32'h7FFF_FFFF);
        check("R7 irq idle", 32'(irq_out), 0);
        pin_level[33] = 1'b1;
        step(1);
        check("R7 irq not yet raised", 32'(irq_out), 0);
        step(1);
        check("R7 irq raised", 32'(irq_out), 1);
        bus_write(8'h94, 32'h0);
        check("R7 irq holds on mask edge", 32'(irq_out), 1);
        step(1);
        check("R7 irq drops after mask", 32'(irq_out), 0);
        bus_write(8'h94, '1);
        step(1);
        check("R7 irq back after unmask", 32'(irq_out), 1);
        bus_write(8'h84, pin_bit(33));
        step(1);
        check("R7 irq drops after clear", 32'(irq_out), 0);
        bus_write(8'h94, pin_bit(33));
        pin_level[50] = 1'b1;
        step(3);
        check("R7 masked pending keeps irq low", 32'(irq_out), 0);
        bus_read(8'h84, d); check("R7 masked pin still pending", d, pin_bit(50));
        bus_write(8'h84, '1);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pin_level[11] = 1'b1; pin_level[12] = 1'b1;
        step(1);
        bus_read(8'h80, d); check("R8 setup pending", d, 32'h1800);
        pin_level[11] = 1'b0;
        step(1);
        pin_level[11] = 1'b1;
        bus_write(8'h80, 32'h1800);
        bus_read(8'h80, d); check("R8 detect beats clear", d, 32'h0800);
        bus_write(8'h80, 32'h0800);
        bus_read(8'h80, d); check("R8 later clear works", d, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h90, 32'h0);
        pin_level[20] = 1'b1;
        step(1);
        bus_write(8'h8C, '1);
        bus_write(8'h81, '1);
        bus_write(8'h7C, '1);
        bus_write(8'h9C, '1);
        bus_write(8'hA0, '1);
        bus_write(8'h91, '1);
        bus_read(8'h80, d); check("R10 status untouched", d, pin_bit(20));
        bus_read(8'h90, d); check("R10 enable untouched", d, 0);
        bus_read(8'h8C, d); check("R10 unmapped reads zero", d, 0);
        bus_read(8'h81, d); check("R10 unaligned reads zero", d, 0);
        bus_write(8'h80, '1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rising();
        t_falling();
        t_level_low();
        t_level_high();
        t_w1c();
        t_enable_irq();
        t_collision();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule